// File: doc/BRIEF.md
# NOR Flash Byte Programmer with Verify and Retry

This block writes a run of bytes into a parallel NOR flash through a simple request/acknowledge bus. A start pulse loads a first address and a byte count. The block then takes one byte per address from a valid/ready source stream. Each byte that differs from the erased value gets a program attempt. An attempt is the three-write unlock preamble, the data write to the target, a toggle-bit wait for the device to go idle, and a read-back of the target.

When the read-back does not match, the whole attempt is repeated, up to a fixed number of attempts per byte. A byte that still mismatches after the last attempt is recorded in a sticky failure flag, and the block continues with the next address. When the last byte has been handled, a one-cycle completion pulse is raised. The failure flag is valid from that pulse until the next start. The unlock sequencer and the toggle poller are separate submodules that share the one bus with the verify read.

Top module: `nor_byte_prog`

## Requirements
- R1: After reset, `busy`, `done`, `failed` and `bus_req` are 0, `src_ready` is 0 and `progress` is 0.
- R2: A start with `length` equal to 0 raises `done` in the cycle after the start edge. It makes no bus request and leaves `failed` at 0.
- R3: A source byte equal to 0xFF is consumed without any bus write to its address. It counts toward `progress` and never sets `failed`.
- R4: Every program attempt issues exactly four writes, in this order: 0xAA to address 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, and then the source byte to the target address.
- R5: After the data write, the block reads the target back to back until two consecutive reads agree in bit 6. It starts no further write and no verify read before that.
- R6: An attempt succeeds when the read-back byte equals the source byte. A byte that needs k failed attempts therefore gets k+1 attempts, when k+1 is at most 16.
- R7: A byte is given at most 16 attempts. After 16 mismatches it is marked failed, and the block proceeds to the next address without aborting.
- R8: `failed` is sticky over the whole range and valid when `done` pulses. A new start clears it. `done` is a single-cycle pulse.
- R9: Exactly one source byte is accepted per address. Addresses increase by one from `start_addr`. `progress` counts the bytes finished and equals `length` at `done`.
- R10: While `bus_req` is high without `bus_ack`, the request, direction, address and write data hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a range; sampled only when idle |
| start_addr | input | ADDR_W | First target address |
| length | input | ADDR_W+1 | Number of bytes in the range |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts the source byte this cycle |
| bus_req | output | 1 | Flash bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | 8 | Flash write data |
| bus_ack | input | 1 | Bus transfer complete; read data valid |
| bus_rdata | input | 8 | Flash read data |
| busy | output | 1 | A range is in progress |
| done | output | 1 | One-cycle pulse: range finished |
| failed | output | 1 | Sticky: some byte exhausted its attempts |
| progress | output | ADDR_W+1 | Bytes finished in the current range |

## Verification
Two events can fall in the same cycle: the final verdict on a byte that has run out of attempts, and the completion of the range. The bench provokes this by making the last byte of a range fail more often than the attempt limit allows. It then judges that `failed` is already high when the `done` pulse is seen, and that `progress` equals the length. A further range that passes on every byte must show `failed` cleared. This confirms that the flag is sticky within a range but reset by a new start.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAUNCH,
        ST_PROG,
        ST_POLL,
        ST_VERIFY
    } prog_st_e;

    localparam logic [7:0] UNLOCK_D0  = 8'hAA;
    localparam logic [7:0] UNLOCK_D1  = 8'h55;
    localparam logic [7:0] PROG_OPC   = 8'hA0;
    localparam logic [15:0] CMD_ADR_A = 16'h5555;
    localparam logic [15:0] CMD_ADR_B = 16'h2AAA;

endpackage

// File: rtl/nor_unlock_seq.sv
module nor_unlock_seq
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic              fin
);
    localparam int STEPS  = 4;
    localparam int STEP_W = $clog2(STEPS);

    typedef struct packed {
        logic              act;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (!q.act && go) begin
            d.act  = 1'b1;
            d.step = '0;
        end else if (q.act && ack) begin
            if (q.step == STEP_W'(STEPS - 1)) begin
                d.act = 1'b0;
                fin   = 1'b1;
            end else begin
                d.step = q.step + 1'b1;
            end
        end
    end

    always_comb begin
        req = q.act;
        case (q.step)
            STEP_W'(0): begin addr = ADDR_W'(CMD_ADR_A); wdata = DATA_W'(UNLOCK_D0); end
            STEP_W'(1): begin addr = ADDR_W'(CMD_ADR_B); wdata = DATA_W'(UNLOCK_D1); end
            STEP_W'(2): begin addr = ADDR_W'(CMD_ADR_A); wdata = DATA_W'(PROG_OPC);  end
            default:    begin addr = tgt_addr;           wdata = tgt_data;           end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !q.act);

endmodule

// File: rtl/nor_ready_poll.sv
module nor_ready_poll #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int TOG_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] poll_addr,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              fin
);
    typedef struct packed {
        logic act;
        logic have_prev;
        logic prev_bit;
    } poll_t;

    poll_t q, d;

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (!q.act && go) begin
            d.act       = 1'b1;
            d.have_prev = 1'b0;
        end else if (q.act && ack) begin
            if (q.have_prev && (rdata[TOG_BIT] == q.prev_bit)) begin
                d.act = 1'b0;
                fin   = 1'b1;
            end else begin
                d.have_prev = 1'b1;
                d.prev_bit  = rdata[TOG_BIT];
            end
        end
    end

    assign req  = q.act;
    assign addr = poll_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> q.have_prev);

endmodule

// File: rtl/nor_byte_prog.sv
module nor_byte_prog
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_TRIES = 16,
    parameter int TOG_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   length,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              failed,
    output logic [ADDR_W:0]   progress
);
    localparam int DATA_W = 8;
    localparam int LEN_W  = ADDR_W + 1;
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef struct packed {
        prog_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  progress;
        logic [TRY_W-1:0]  tries;
        logic [DATA_W-1:0] data;
        logic              failed;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic              seq_go, seq_req, seq_fin;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_wdata;
    logic              poll_go, poll_req, poll_fin;
    logic [ADDR_W-1:0] poll_addr;
    logic              vfy_req, byte_end;

    nor_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (seq_go),
        .tgt_addr (q.addr),
        .tgt_data (q.data),
        .req      (seq_req),
        .addr     (seq_addr),
        .wdata    (seq_wdata),
        .ack      (bus_ack),
        .fin      (seq_fin)
    );

    nor_ready_poll #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOG_BIT(TOG_BIT)) poll_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (poll_go),
        .poll_addr (q.addr),
        .req       (poll_req),
        .addr      (poll_addr),
        .ack       (bus_ack),
        .rdata     (bus_rdata),
        .fin       (poll_fin)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        seq_go    = 1'b0;
        poll_go   = 1'b0;
        src_ready = 1'b0;
        vfy_req   = 1'b0;
        byte_end  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr     = start_addr;
                    d.remain   = length;
                    d.progress = '0;
                    d.failed   = 1'b0;
                    if (length == '0) d.done = 1'b1;
                    else              d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    d.data  = src_data;
                    d.tries = '0;
                    if (src_data == ERASED) byte_end = 1'b1;
                    else                    d.st     = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                seq_go = 1'b1;
                d.st   = ST_PROG;
            end
            ST_PROG: begin
                if (seq_fin) begin
                    poll_go = 1'b1;
                    d.st    = ST_POLL;
                end
            end
            ST_POLL: begin
                if (poll_fin) d.st = ST_VERIFY;
            end
            ST_VERIFY: begin
                vfy_req = 1'b1;
                if (bus_ack) begin
                    d.tries = q.tries + 1'b1;
                    if (bus_rdata == q.data) begin
                        byte_end = 1'b1;
                    end else if (q.tries == TRY_W'(MAX_TRIES - 1)) begin
                        d.failed = 1'b1;
                        byte_end = 1'b1;
                    end else begin
                        d.st = ST_LAUNCH;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (byte_end) begin
            d.progress = q.progress + 1'b1;
            d.addr     = q.addr + 1'b1;
            d.remain   = q.remain - 1'b1;
            if (q.remain == LEN_W'(1)) begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end else begin
                d.st = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign bus_req   = seq_req | poll_req | vfy_req;
    assign bus_we    = seq_req;
    assign bus_addr  = seq_req ? seq_addr : (poll_req ? poll_addr : q.addr);
    assign bus_wdata = seq_wdata;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign failed    = q.failed;
    assign progress  = q.progress;

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_req && poll_req));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !bus_req);

    // R7
    tries_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries <= TRY_W'(MAX_TRIES));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.remain != '0));

endmodule

// File: tb/nor_byte_prog_tb_top.sv
module nor_byte_prog_tb_top;
    localparam int ADDR_W = 16;
    localparam int LIMIT  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [ADDR_W:0]   length = '0;
    logic              src_valid;
    logic [7:0]        src_data;
    logic              src_ready;
    logic              bus_req, bus_we, bus_ack, busy, done, failed;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rdata;
    logic [ADDR_W:0]   progress;

    nor_byte_prog #(.ADDR_W(ADDR_W), .MAX_TRIES(LIMIT), .TOG_BIT(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .length(length), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .failed(failed),
        .progress(progress)
    );

    // flash and source model
    logic [7:0] mem     [256];
    int         fail_k  [256];
    int         att     [256];
    logic [7:0] src_mem [64];
    int  src_idx, consumed, ops, proto_err, early_err, busy_cnt, stage;
    logic tog, ack_q, clr;

    assign bus_ack   = ack_q;
    assign src_valid = busy;
    assign src_data  = src_mem[src_idx[5:0]];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) begin mem[i] <= 8'hFF; att[i] <= 0; end
            src_idx <= 0; consumed <= 0; ops <= 0; proto_err <= 0; early_err <= 0;
            busy_cnt <= 0; stage <= 0; tog <= 1'b0; ack_q <= 1'b0; bus_rdata <= 8'h00;
        end else begin
            if (src_valid && src_ready) begin
                src_idx  <= src_idx + 1;
                consumed <= consumed + 1;
            end
            if (bus_req && !ack_q) begin
                ack_q <= 1'b1;
                ops   <= ops + 1;
                if (bus_we) begin
                    if (busy_cnt != 0) early_err <= early_err + 1;
                    if (stage == 0 && bus_addr == 16'h5555 && bus_wdata == 8'hAA) stage <= 1;
                    else if (stage == 1 && bus_addr == 16'h2AAA && bus_wdata == 8'h55) stage <= 2;
                    else if (stage == 2 && bus_addr == 16'h5555 && bus_wdata == 8'hA0) stage <= 3;
                    else if (stage == 3) begin
                        int a;
                        a = int'(bus_addr[7:0]);
                        att[a] <= att[a] + 1;
                        if (att[a] + 1 > fail_k[a]) mem[a] <= mem[a] & bus_wdata;
                        busy_cnt <= 3;
                        stage <= 0;
                    end else begin
                        proto_err <= proto_err + 1;
                        stage <= 0;
                    end
                end else begin
                    if (busy_cnt != 0) begin
                        bus_rdata <= {1'b0, tog, 6'h0};
                        tog <= ~tog;
                        busy_cnt <= busy_cnt - 1;
                    end else begin
                        bus_rdata <= mem[bus_addr[7:0]];
                    end
                end
            end else begin
                ack_q <= 1'b0;
            end
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    // returns cycles from start to done, -1 on timeout
    task automatic run(input logic [ADDR_W-1:0] a, input int n, output int cyc);
        start_addr = a;
        length     = (ADDR_W+1)'(n);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            cyc = -1;
            check(1'b0, "watchdog", 0, 1);
        end
    endtask

    task automatic check_range(input int base, input int n, input bit exp_fail);
        for (int i = 0; i < n; i++) begin
            int a, k, exp_att;
            logic [7:0] dv, exp_m;
            a  = (base + i) & 255;
            k  = fail_k[a];
            dv = src_mem[i];
            if (dv == 8'hFF) begin
                exp_att = 0; exp_m = 8'hFF;
                check(att[a] == exp_att, "R3 skipped byte attempts", att[a], exp_att);
            end else begin
                exp_att = (k + 1 > LIMIT) ? LIMIT : k + 1;
                exp_m   = (k < LIMIT) ? dv : 8'hFF;
                if (k < LIMIT) check(att[a] == exp_att, "R6 attempts", att[a], exp_att);
                else           check(att[a] == exp_att, "R7 attempt limit", att[a], exp_att);
            end
            check(mem[a] == exp_m, "R6 stored byte", mem[a], exp_m);
        end
        check(failed == exp_fail, "R8 failed at done", failed, exp_fail);
        check(progress == (ADDR_W+1)'(n), "R9 progress", progress, n);
        check(consumed == n, "R9 bytes consumed", consumed, n);
        check(proto_err == 0, "R4 write order", proto_err, 0);
        check(early_err == 0, "R5 write while device busy", early_err, 0);
    endtask

    initial begin
        int cyc;
        int ops0;
        clr = 1'b1;
        for (int i = 0; i < 256; i++) fail_k[i] = 0;
        for (int i = 0; i < 64; i++) src_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check(!busy && !done && !failed && !bus_req && !src_ready && progress == '0,
              "R1 reset state", {busy, done, failed, bus_req}, 0);
        rst_n = 1'b1;
        clr   = 1'b0;
        @(negedge clk);

        // range with retries, a skip, a limit hit, last byte failing
        prep();
        begin
            int ks[8] = '{0, 1, 0, 3, 15, 16, 0, 20};
            logic [7:0] ds[8] = '{8'h3C, 8'hA5, 8'hFF, 8'h12, 8'h00, 8'h7E, 8'h81, 8'h55};
            for (int i = 0; i < 8; i++) begin
                fail_k[(16'h0100 + i) & 255] = ks[i];
                src_mem[i] = ds[i];
            end
        end
        run(16'h0100, 8, cyc);
        check_range(16'h0100, 8, 1'b1);
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
        check(failed, "R8 failed sticky after done", failed, 1);

        // zero length
        prep();
        run(16'h0040, 0, cyc);
        check(cyc == 1, "R2 zero length done latency", cyc, 1);
        check(ops == 0, "R2 no bus activity", ops, 0);
        check(!failed, "R2 failed cleared", failed, 0);

        // sweep of passing ranges with varying retries and lengths
        for (int len = 1; len <= 24; len += 7) begin
            prep();
            for (int i = 0; i < 256; i++) fail_k[i] = 0;
            for (int i = 0; i < len; i++) begin
                src_mem[i] = 8'((i * 37) ^ 8'h5A);
                fail_k[(16'h0140 + i) & 255] = i % 4;
            end
            if (len > 3) src_mem[3] = 8'hFF;
            run(16'h0140, len, cyc);
            check_range(16'h0140, len, 1'b0);
        end

        // skip-only range: no bus traffic at all
        prep();
        for (int i = 0; i < 5; i++) src_mem[i] = 8'hFF;
        ops0 = 0;
        run(16'h0180, 5, cyc);
        check(ops == ops0, "R3 skip-only range bus ops", ops, ops0);
        check(progress == 5, "R9 skip-only progress", progress, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule